// File: doc/BRIEF.md
# Blanking-Period Packet Slot Scheduler

This block decides which auxiliary packets a display transmitter sends in each blanking interval, and in what order. Software programs two slot words. Each word holds four 4-bit packet type codes. Together the eight slots form an ordered transmit list. A packet engine downstream builds and serialises the packets. This block only hands it one type code at a time and waits until that packet is finished.

When a blanking-start pulse arrives and the scheduler is idle, it walks the list from the first slot. A slot that holds a transmittable code raises a one-cycle request carrying that code. The scheduler then waits for the engine's done pulse before it looks at the next slot. A slot that holds an unassigned code is passed over without a request. A slot that holds the terminator code stops the walk at once. With no terminator, the walk stops after the eighth slot. A typical list holds general control, then the video information frame, then the audio information frame, then the terminator.

Top module: `pkt_slot_scheduler`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy` and `reqStrobe` are 0.
- R2: A `blankStart` pulse sampled while idle makes `busy` read 1 in the next cycle. The walk then begins at slot 0 of the low word.
- R3: Slot n of a slot word is bits [4n+3:4n]. Slots are visited as low word slots 0 to 3, then high word slots 0 to 3. Requests come out in exactly that order.
- R4: A transmittable code gives exactly one `reqStrobe` cycle. `pktType` equals the slot's code during that cycle, and `busy` is 1.
- R5: After a request, no further request is issued until `pktDone` has been sampled high.
- R6: Code 15 is the terminator. It issues no request and ends the walk, so `busy` falls. Later slots are not visited in that period.
- R7: Transmittable codes are 0 (null), 1 (general control), 2 (video information frame), 3 (audio information frame) and 5 (product description). Codes 4 and 6 to 14 are passed over without a request.
- R8: When no slot holds the terminator, the walk ends after high word slot 3, with at most eight requests.
- R9: A `blankStart` pulse while `busy` is 1 is ignored. A running walk is never restarted, and no extra requests follow.
- R10: A `pktDone` pulse while idle has no effect: `busy` and `reqStrobe` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotWordLo | input | 16 | Slots 0 to 3 of the list, 4 bits each |
| slotWordHi | input | 16 | Slots 4 to 7 of the list, 4 bits each |
| blankStart | input | 1 | One-cycle pulse at the start of a blanking period |
| pktDone | input | 1 | Packet engine has finished the requested packet |
| reqStrobe | output | 1 | One-cycle request for a packet |
| pktType | output | 4 | Type code of the requested packet |
| busy | output | 1 | A list walk is in progress |

## Verification
The bench uses the default parameters: two words of four 4-bit slots and terminator code 15. At that size every slot position can be reached with a handful of vectors, including a terminator in slot 0, one in the high word, and a list with no terminator that runs through all eight slots. Vectors mix skipped codes between transmittable ones. They vary the done latency from zero to three cycles, so back-to-back requests and long waits are both covered. One vector fires a second blanking pulse in the middle of a walk.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] pktCode_t;

  // Packet type codes; the list order is set by software.
  localparam pktCode_t CODE_NULL    = 4'd0;
  localparam pktCode_t CODE_GENCTL  = 4'd1;
  localparam pktCode_t CODE_VIDINFO = 4'd2;
  localparam pktCode_t CODE_AUDINFO = 4'd3;
  localparam pktCode_t CODE_PRODUCT = 4'd5;
  localparam pktCode_t CODE_END     = 4'd15;

  // Bit k set: code k is transmittable.
  localparam logic [2**CODE_W-1:0] DEFAULT_SEND_MASK =
    (16'd1 << CODE_NULL) | (16'd1 << CODE_GENCTL) | (16'd1 << CODE_VIDINFO) |
    (16'd1 << CODE_AUDINFO) | (16'd1 << CODE_PRODUCT);

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearIdx;
    logic advIdx;
    logic loadReq;
  } schedCtl_t;

  // Classification of the current slot, datapath to control.
  typedef struct packed {
    logic isEnd;
    logic isSend;
    logic isLast;
  } slotStat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } schedState_t;

endpackage

// File: rtl/pkt_sched_datapath.sv
module pkt_sched_datapath
  import pkt_sched_pkg::*;
#(
  parameter int CODE_BITS     = CODE_W,
  parameter int SLOTS_PER_REG = 4,
  parameter int NUM_REGS      = 2,
  parameter logic [2**CODE_BITS-1:0] SEND_MASK = DEFAULT_SEND_MASK,
  parameter logic [CODE_BITS-1:0] END_CODE = CODE_END,
  localparam int REG_W = SLOTS_PER_REG * CODE_BITS,
  localparam int TOTAL = NUM_REGS * SLOTS_PER_REG
) (
  input  logic clk,
  input  logic rst,
  input  schedCtl_t ctl,
  input  logic [NUM_REGS-1:0][REG_W-1:0] slotRegs,
  output slotStat_t stat,
  output logic reqStrobe,
  output logic [CODE_BITS-1:0] pktType
);

  localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic [CODE_BITS-1:0] slotArr [TOTAL];
  logic [IDX_W-1:0] slotIdx;
  logic [CODE_BITS-1:0] curCode;

  // Flatten the words into one ordered slot list: word 0 first.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar s = 0; s < SLOTS_PER_REG; s++) begin : g_slot
      assign slotArr[r*SLOTS_PER_REG + s] = slotRegs[r][s*CODE_BITS +: CODE_BITS];
    end
  end

  assign curCode     = slotArr[slotIdx];
  assign stat.isEnd  = (curCode == END_CODE);
  assign stat.isSend = SEND_MASK[curCode];
  assign stat.isLast = (slotIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotIdx   <= '0;
      reqStrobe <= 1'b0;
      pktType   <= '0;
    end else begin
      reqStrobe <= ctl.loadReq;
      if (ctl.loadReq) pktType <= curCode;
      if (ctl.clearIdx)    slotIdx <= '0;
      else if (ctl.advIdx) slotIdx <= slotIdx + 1'b1;
    end
  end

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reqStrobe |=> !reqStrobe); // R4
  AST_REQ_CODE_SENDABLE: assert property (@(posedge clk) disable iff (rst)
    reqStrobe |-> SEND_MASK[pktType]); // R7
  AST_IDX_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ctl.advIdx |-> !stat.isLast); // R8

endmodule

// File: rtl/pkt_sched_control.sv
module pkt_sched_control
  import pkt_sched_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic blankStart,
  input  logic pktDone,
  input  slotStat_t stat,
  output schedCtl_t ctl,
  output logic busy
);

  schedState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (blankStart) begin
          ctl.clearIdx = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (stat.isEnd) begin
          stateNext = ST_IDLE;
        end else if (stat.isSend) begin
          ctl.loadReq = 1'b1;
          stateNext = ST_WAIT;
        end else if (stat.isLast) begin
          stateNext = ST_IDLE;
        end else begin
          ctl.advIdx = 1'b1;
        end
      end
      ST_WAIT: begin
        if (pktDone) begin
          if (stat.isLast) begin
            stateNext = ST_IDLE;
          end else begin
            ctl.advIdx = 1'b1;
            stateNext = ST_SCAN;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && blankStart) |=> busy); // R2
  AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !pktDone) |=> (state == ST_WAIT)); // R5
  AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && stat.isEnd) |=> !busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && blankStart) |-> !ctl.clearIdx); // R9
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !blankStart && pktDone) |=> !busy); // R10

endmodule

// File: rtl/pkt_slot_scheduler.sv
module pkt_slot_scheduler
  import pkt_sched_pkg::*;
#(
  parameter int SLOTS_PER_REG = 4,
  localparam int REG_W = SLOTS_PER_REG * CODE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [REG_W-1:0] slotWordLo,
  input  logic [REG_W-1:0] slotWordHi,
  input  logic blankStart,
  input  logic pktDone,
  output logic reqStrobe,
  output logic [CODE_W-1:0] pktType,
  output logic busy
);

  schedCtl_t ctl;
  slotStat_t stat;
  logic [1:0][REG_W-1:0] slotRegs;

  assign slotRegs = {slotWordHi, slotWordLo};

  pkt_sched_control u_ctrl (
    .clk(clk),
    .rst(rst),
    .blankStart(blankStart),
    .pktDone(pktDone),
    .stat(stat),
    .ctl(ctl),
    .busy(busy)
  );

  pkt_sched_datapath #(
    .CODE_BITS(CODE_W),
    .SLOTS_PER_REG(SLOTS_PER_REG),
    .NUM_REGS(2)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .slotRegs(slotRegs),
    .stat(stat),
    .reqStrobe(reqStrobe),
    .pktType(pktType)
  );

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    reqStrobe |-> busy); // R4

endmodule

// File: tb/pkt_slot_scheduler_test.sv
module pkt_slot_scheduler_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] slotWordLo = '0;
  logic [15:0] slotWordHi = '0;
  logic blankStart = 1'b0;
  logic pktDone = 1'b0;
  logic reqStrobe;
  logic [3:0] pktType;
  logic busy;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pkt_slot_scheduler uut (
    .clk(clk), .rst(rst),
    .slotWordLo(slotWordLo), .slotWordHi(slotWordHi),
    .blankStart(blankStart), .pktDone(pktDone),
    .reqStrobe(reqStrobe), .pktType(pktType), .busy(busy)
  );

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
    logic [31:0] delay;
    logic [31:0] expCount;
    logic [31:0] expTypes;   // request k in bits [4k+3:4k]
    logic poke;              // second blanking pulse mid-walk
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'hF321, 16'h0000, 32'd0, 32'd3, 32'h0000_0321, 1'b0}, // R3 typical list
    '{16'h5555, 16'h0000, 32'd1, 32'd8, 32'h0000_5555, 1'b0}, // R8 no terminator
    '{16'h4E6C, 16'hF302, 32'd2, 32'd3, 32'h0000_0302, 1'b1}, // R7 skips, R9 poke
    '{16'h123F, 16'h1111, 32'd0, 32'd0, 32'h0000_0000, 1'b0}, // R6 end in slot 0
    '{16'h5E05, 16'h1F32, 32'd3, 32'd5, 32'h0003_2505, 1'b0}, // R6 end in high word
    '{16'h0000, 16'h0000, 32'd0, 32'd8, 32'h0000_0000, 1'b0}, // R8 all null
    '{16'h3210, 16'hF5D1, 32'd1, 32'd6, 32'h0051_3210, 1'b1}  // R3 R7 R9
  };

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic runWalk(input vec_t v);
    int gotCount = 0;
    logic [31:0] gotTypes = '0;
    int guard = 0;
    bit waitViol = 1'b0;
    slotWordLo = v.lo;
    slotWordHi = v.hi;
    @(negedge clk);
    blankStart = 1'b1;
    @(negedge clk);
    blankStart = 1'b0;
    check(busy == 1'b1, "R2 busy after pulse", {31'd0, busy}, 32'd1);
    while (busy && guard < 200) begin
      guard++;
      if (reqStrobe) begin
        if (gotCount < 8) gotTypes[4*gotCount +: 4] = pktType;
        gotCount++;
        if (v.poke && gotCount == 1) begin
          blankStart = 1'b1;
          @(negedge clk);
          blankStart = 1'b0;
        end
        for (int d = 0; d < int'(v.delay); d++) begin
          @(negedge clk);
          if (reqStrobe) waitViol = 1'b1;
        end
        pktDone = 1'b1;
        @(negedge clk);
        pktDone = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(guard < 200, "R8 walk terminates", guard, 32'd200);
    check(!waitViol, "R5 no request before done", {31'd0, waitViol}, 32'd0);
    check(gotCount == int'(v.expCount), "R6 R8 request count", gotCount, v.expCount);
    check(gotTypes == v.expTypes, "R3 R4 R7 request order", gotTypes, v.expTypes);
    // R9: nothing restarts after the walk ends
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!busy && !reqStrobe, "R9 no restart", {30'd0, busy, reqStrobe}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !reqStrobe, "R1 in reset", {30'd0, busy, reqStrobe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !reqStrobe, "R1 after reset", {30'd0, busy, reqStrobe}, 32'd0);

    // R10: done while idle
    pktDone = 1'b1;
    @(negedge clk);
    pktDone = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!busy && !reqStrobe, "R10 idle done ignored", {30'd0, busy, reqStrobe}, 32'd0);
    end

    for (int i = 0; i < NVEC; i++) runWalk(VECS[i]);

    // R1: reset in mid-walk returns to idle
    slotWordLo = 16'h5555;
    slotWordHi = 16'h5555;
    @(negedge clk);
    blankStart = 1'b1;
    @(negedge clk);
    blankStart = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !reqStrobe, "R1 reset aborts walk", {30'd0, busy, reqStrobe}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule